// File: doc/BRIEF.md
# Alert Cadence Sequencer with Priority

This block decides, slot by slot, whether the alert transducers of a paging receiver are switched on. Software writes an 8-bit cadence word. The block steps through it one bit per 62.5 ms slot, starting with the top bit, and repeats it until the word is rewritten. When the last slot begins, it raises a reload interrupt so software can supply the next word in time.

A write to the set-up register with its start bit set launches a built-in standard alert. The standard alert runs for 16 s using one of four fixed slot patterns. It takes over from the cadence while it runs, and the cadence then continues from the slot where it stopped. A direct alarm input outranks both sources.

Each of the three gate outputs (acoustic, LED, vibrator) has its own enable bit. Tone generation and drive levels belong to other blocks. The slot rate comes from an external one-cycle tick.

Top module: `alert_cadence_top`

## Requirements
- R1: In cadence mode, `gateOut` shows the enabled outputs during slot k when bit (7-k) of the active cadence word is 1. The first slot uses bit 7 and the last uses bit 0. `gateOut` bit 0 is acoustic, bit 1 is LED and bit 2 is vibrator. The word repeats with no further writes.
- R2: Set-up register bits 3, 4 and 5 enable the acoustic, LED and vibrator gates. A disabled gate stays 0 whatever the source.
- R3: The tick that starts the final slot (bit 0) sets status bit 0. `irqOut` is high while any status bit is set.
- R4: Status bits stay set until a write to address 2 with a 1 in that bit position. Address 0 is the set-up register, address 1 the cadence word and address 2 the status clear.
- R5: A nonzero cadence word written while a pattern runs is held back and becomes active at the next pattern start. Written while idle, it starts at once at bit 7.
- R6: Writing an all-zero cadence word while a pattern runs stops the gates at the next slot tick.
- R7: A set-up write with bit 0 set starts a standard alert. Bits 7:6 choose its pattern: 0 gives F0h, 1 gives CCh, 2 gives AAh and 3 gives EEh, each sent bit 7 first and repeated. The standard alert overrides the cadence for 256 slot ticks.
- R8: At the end of a standard alert, status bit 4 is set.
- R9: After a standard alert, a cadence that was running resumes from the slot position it had reached.
- R10: If the direct alarm input is high while an alert is running, every enabled gate is on one clock later.
- R11: If the direct alarm input is high while no alert is running, the gates switch on one clock later than in R10, so two clocks after the input rises.
- R12: Gates are registered. They change one clock after the tick or input that causes the change, and they and the status are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select (0 set-up, 1 cadence, 2 status clear) |
| wrData | input | 8 | Write data |
| slotTick | input | 1 | One-cycle pulse per 62.5 ms slot |
| alarmIn | input | 1 | Direct alarm request |
| gateOut | output | 3 | Gates for acoustic, LED and vibrator |
| statusOut | output | 8 | Sticky status (bit 0 reload, bit 4 standard done) |
| irqOut | output | 1 | Interrupt, high while any status bit is set |

## Verification
The bench aims at the following corner cases:

- **Mid-pattern rewrite.** A cadence word is rewritten in the middle of a pattern. A design that applied it at once would show the new bits in the wrong slots.
- **Standard alert over a live cadence.** A standard alert interrupts a running cadence and is then left to finish. A design that restarted the cadence at bit 7, or lost it, would drift from the reference in every later slot.
- **Reload interrupt timing.** The reload flag must appear at the final slot. A design that fired it one slot early or late would show up in the per-clock comparison of `statusOut`.
- **Zero-word stop.** A zero word must stop the gates at the next tick, not at the end of the pattern.
- **Alarm from idle versus during an alert.** The alarm is raised once from idle and once while a pattern runs. A design without the extra idle clock, or one that kept it in both cases, would be off by one cycle.

// File: rtl/alert_pkg.sv
package alert_pkg;

  localparam int PAT_W = 8;

  localparam logic [1:0] ADDR_SETUP  = 2'd0;
  localparam logic [1:0] ADDR_CAD    = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  localparam int SETUP_START = 0;
  localparam int SETUP_EN_LO = 3;
  localparam int SETUP_SEL_LO = 6;
  localparam int NUM_GATES = 3;

  localparam int STAT_RELOAD = 0;
  localparam int STAT_DONE   = 4;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CAD  = 2'd1,
    MODE_STD  = 2'd2
  } seqMode_t;

  typedef struct packed {
    logic loadWr;
    logic loadShadow;
    logic clearCur;
    logic setReload;
    logic setDone;
  } seqStrobe_t;

  function automatic logic [PAT_W-1:0] stdPattern(input logic [1:0] sel);
    logic [PAT_W-1:0] w;
    case (sel)
      2'd0:    w = 8'hF0;
      2'd1:    w = 8'hCC;
      2'd2:    w = 8'hAA;
      default: w = 8'hEE;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/alert_seq_ctrl.sv
module alert_seq_ctrl
  import alert_pkg::*;
#(
  parameter int CAD_W     = 8,
  parameter int STD_SLOTS = 256,
  localparam int POS_W    = $clog2(CAD_W),
  localparam int CNT_W    = $clog2(STD_SLOTS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             slotTick,
  input  logic             stdStart,
  input  logic             cadWrite,
  input  logic             cadWrZero,
  input  logic             curZero,
  output seqStrobe_t       strobe,
  output seqMode_t         mode,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] stdPhase
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CAD_W - 1);
  localparam logic [POS_W-1:0] PRE_LAST = POS_W'(CAD_W - 2);
  localparam logic [CNT_W-1:0] LAST_STD = CNT_W'(STD_SLOTS - 1);

  logic [CNT_W-1:0] stdCnt;
  logic             zeroPend;

  assign stdPhase = stdCnt[POS_W-1:0];

  always_comb begin
    strobe = '0;
    if (slotTick) begin
      case (mode)
        MODE_CAD: begin
          if (zeroPend)               strobe.clearCur   = 1'b1;
          else if (pos == LAST_POS)   strobe.loadShadow = 1'b1;
          else if (pos == PRE_LAST)   strobe.setReload  = 1'b1;
        end
        MODE_STD: begin
          if (stdCnt == LAST_STD)     strobe.setDone    = 1'b1;
        end
        default: ;
      endcase
    end
    if (cadWrite && !cadWrZero && mode == MODE_IDLE) strobe.loadWr = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode     <= MODE_IDLE;
      pos      <= '0;
      stdCnt   <= '0;
      zeroPend <= 1'b0;
    end else begin
      if (slotTick) begin
        case (mode)
          MODE_CAD: begin
            if (zeroPend) begin
              mode     <= MODE_IDLE;
              pos      <= '0;
              zeroPend <= 1'b0;
            end else if (pos == LAST_POS) begin
              pos <= '0;
            end else begin
              pos <= pos + 1'b1;
            end
          end
          MODE_STD: begin
            if (stdCnt == LAST_STD) begin
              stdCnt <= '0;
              if (curZero) begin
                mode     <= MODE_IDLE;
                zeroPend <= 1'b0;
              end else begin
                mode <= MODE_CAD;
              end
            end else begin
              stdCnt <= stdCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (stdStart) begin
        mode   <= MODE_STD;
        stdCnt <= '0;
      end
      if (cadWrite) begin
        if (cadWrZero) begin
          if (mode != MODE_IDLE) zeroPend <= 1'b1;
        end else begin
          zeroPend <= 1'b0;
          if (mode == MODE_IDLE) begin
            mode <= MODE_CAD;
            pos  <= '0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/alert_seq_dp.sv
module alert_seq_dp
  import alert_pkg::*;
#(
  parameter int CAD_W = 8,
  localparam int POS_W = $clog2(CAD_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           wrAddr,
  input  logic [7:0]           wrData,
  input  logic                 alarmIn,
  input  seqStrobe_t           strobe,
  input  seqMode_t             mode,
  input  logic                 running,
  input  logic [POS_W-1:0]     pos,
  input  logic [POS_W-1:0]     stdPhase,
  output logic                 stdStart,
  output logic                 cadWrite,
  output logic                 cadWrZero,
  output logic                 curZero,
  output logic [NUM_GATES-1:0] enBits,
  output logic                 alarmQ,
  output logic [NUM_GATES-1:0] gateOut,
  output logic [7:0]           statusOut,
  output logic                 irqOut
);

  localparam logic [POS_W-1:0] TOP_BIT = POS_W'(CAD_W - 1);

  logic [1:0]       stdSel;
  logic [CAD_W-1:0] cadShadow;
  logic [CAD_W-1:0] cadCur;
  logic [CAD_W-1:0] stdWord;
  logic [7:0]       statusReg;
  logic [7:0]       setMask;
  logic [7:0]       clrMask;
  logic             setupWr;
  logic             patBit;
  logic             alarmHit;

  assign setupWr   = wrEn && (wrAddr == ADDR_SETUP);
  assign stdStart  = setupWr && wrData[SETUP_START];
  assign cadWrite  = wrEn && (wrAddr == ADDR_CAD);
  assign cadWrZero = (wrData[CAD_W-1:0] == '0);
  assign curZero   = (cadCur == '0);
  assign stdWord   = stdPattern(stdSel);

  always_comb begin
    setMask = '0;
    setMask[STAT_RELOAD] = strobe.setReload;
    setMask[STAT_DONE]   = strobe.setDone;
    clrMask = (wrEn && wrAddr == ADDR_STATUS) ? wrData : 8'h00;
  end

  always_comb begin
    case (mode)
      MODE_CAD: patBit = cadCur[TOP_BIT - pos];
      MODE_STD: patBit = stdWord[TOP_BIT - stdPhase];
      default:  patBit = 1'b0;
    endcase
  end

  assign alarmHit = alarmIn && (running || alarmQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stdSel    <= '0;
      enBits    <= '0;
      cadShadow <= '0;
      cadCur    <= '0;
      statusReg <= '0;
      alarmQ    <= 1'b0;
      gateOut   <= '0;
    end else begin
      if (setupWr) begin
        stdSel <= wrData[SETUP_SEL_LO +: 2];
        enBits <= wrData[SETUP_EN_LO +: NUM_GATES];
      end
      if (cadWrite) cadShadow <= wrData[CAD_W-1:0];
      if (strobe.loadWr)          cadCur <= wrData[CAD_W-1:0];
      else if (strobe.loadShadow) cadCur <= cadShadow;
      else if (strobe.clearCur)   cadCur <= '0;
      statusReg <= (statusReg & ~clrMask) | setMask;
      alarmQ    <= alarmIn;
      gateOut   <= (alarmHit || patBit) ? enBits : '0;
    end
  end

  assign statusOut = statusReg;
  assign irqOut    = |statusReg;

endmodule

// File: rtl/alert_cadence_top.sv
module alert_cadence_top
  import alert_pkg::*;
#(
  parameter int CAD_W     = alert_pkg::PAT_W,
  parameter int STD_SLOTS = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       slotTick,
  input  logic       alarmIn,
  output logic [2:0] gateOut,
  output logic [7:0] statusOut,
  output logic       irqOut
);

  localparam int POS_W = $clog2(CAD_W);

  seqStrobe_t           strobe;
  seqMode_t             mode;
  logic [POS_W-1:0]     pos;
  logic [POS_W-1:0]     stdPhase;
  logic                 stdStart;
  logic                 cadWrite;
  logic                 cadWrZero;
  logic                 curZero;
  logic                 running;
  logic                 alarmQ;
  logic [NUM_GATES-1:0] enBits;

  assign running = (mode != MODE_IDLE);

  alert_seq_ctrl #(.CAD_W(CAD_W), .STD_SLOTS(STD_SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .slotTick(slotTick), .stdStart(stdStart),
    .cadWrite(cadWrite), .cadWrZero(cadWrZero), .curZero(curZero),
    .strobe(strobe), .mode(mode), .pos(pos), .stdPhase(stdPhase)
  );

  alert_seq_dp #(.CAD_W(CAD_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .alarmIn(alarmIn), .strobe(strobe), .mode(mode), .running(running),
    .pos(pos), .stdPhase(stdPhase), .stdStart(stdStart), .cadWrite(cadWrite),
    .cadWrZero(cadWrZero), .curZero(curZero), .enBits(enBits), .alarmQ(alarmQ),
    .gateOut(gateOut), .statusOut(statusOut), .irqOut(irqOut)
  );

endmodule

// File: rtl/alert_seq_checker.sv
module alert_seq_checker
  import alert_pkg::*;
#(
  parameter int POS_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             alarmIn,
  input logic             alarmQ,
  input logic             running,
  input logic [2:0]       enBits,
  input logic [2:0]       gateOut,
  input logic [7:0]       statusOut,
  input seqStrobe_t       strobe,
  input logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] LAST_POS = {POS_W{1'b1}};

  AST_GATE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    ((gateOut & ~$past(enBits)) == 3'b000)); // R2

  AST_ALARM_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    (alarmIn && running) |=> (gateOut == $past(enBits))); // R10

  AST_IDLE_ALARM_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !alarmQ) |=> (gateOut == 3'b000)); // R11

  AST_RELOAD_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setReload |=> (pos == LAST_POS && statusOut[STAT_RELOAD])); // R3

  AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setDone |=> statusOut[STAT_DONE]); // R8

endmodule

bind alert_cadence_top alert_seq_checker #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rstN(rstN), .alarmIn(alarmIn), .alarmQ(alarmQ),
  .running(running), .enBits(enBits), .gateOut(gateOut),
  .statusOut(statusOut), .strobe(strobe), .pos(pos)
);

// File: tb/test_alert_cadence_top.sv
module test_alert_cadence_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic       slotTick = 1'b0;
  logic       alarmIn = 1'b0;
  logic [2:0] gateOut;
  logic [7:0] statusOut;
  logic       irqOut;

  int    total = 0;
  int    bad = 0;
  string curReq = "R12";
  bit    finished = 1'b0;

  always #5 clk = ~clk;

  alert_cadence_top i_alert_cadence_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .slotTick(slotTick), .alarmIn(alarmIn), .gateOut(gateOut),
    .statusOut(statusOut), .irqOut(irqOut)
  );

  // behavioural reference: 0 idle, 1 cadence, 2 standard alert
  int         mMode, mPos, mCnt;
  logic [7:0] mCur, mShadow, mSetup, mStatus;
  bit         mZeroPend, mAlarmQ;
  logic [2:0] mGate;

  function automatic logic [7:0] refStd(input int sel);
    case (sel)
      0: return 8'hF0;
      1: return 8'hCC;
      2: return 8'hAA;
      default: return 8'hEE;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mPos = 0; mCnt = 0; mCur = 0; mShadow = 0; mSetup = 0;
      mStatus = 0; mZeroPend = 0; mAlarmQ = 0; mGate = 0;
    end else begin
      bit on;
      logic [7:0] w;
      on = 0;
      if (mMode == 1) on = mCur[7 - mPos];
      else if (mMode == 2) begin
        w = refStd(int'(mSetup[7:6]));
        on = w[7 - (mCnt % 8)];
      end
      if (alarmIn && (mMode != 0 || mAlarmQ)) on = 1;
      mGate = on ? mSetup[5:3] : 3'b000;
      mAlarmQ = alarmIn;
      if (slotTick) begin
        if (mMode == 1) begin
          if (mZeroPend) begin
            mMode = 0; mPos = 0; mZeroPend = 0; mCur = 0;
          end else begin
            if (mPos == 6) mStatus[0] = 1'b1;
            if (mPos == 7) begin mPos = 0; mCur = mShadow; end
            else mPos++;
          end
        end else if (mMode == 2) begin
          if (mCnt == 255) begin
            mStatus[4] = 1'b1; mCnt = 0;
            if (mCur == 0) begin mMode = 0; mZeroPend = 0; end
            else mMode = 1;
          end else mCnt++;
        end
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: begin
            mSetup = wrData;
            if (wrData[0]) begin mMode = 2; mCnt = 0; end
          end
          2'd1: begin
            mShadow = wrData;
            if (wrData == 0) begin
              if (mMode != 0) mZeroPend = 1;
            end else begin
              mZeroPend = 0;
              if (mMode == 0) begin mMode = 1; mPos = 0; mCur = wrData; end
            end
          end
          2'd2: mStatus = mStatus & ~wrData;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk({curReq, " gate"}, int'(gateOut), int'(mGate));
      chk({curReq, " status"}, int'(statusOut), int'(mStatus));
      chk({curReq, " irq"}, int'(irqOut), int'(mStatus != 0));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = 8'h00;
  endtask

  task automatic slots(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slotTick = 1'b1;
      @(negedge clk); slotTick = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset gate", int'(gateOut), 0);
    chk("R12 reset status", int'(statusOut), 0);
    chk("R12 reset irq", int'(irqOut), 0);
    rstN = 1'b1;

    curReq = "R1";
    wr(2'd0, 8'h38);
    wr(2'd1, 8'hA5);
    @(negedge clk);
    chk("R5 idle start bit7", int'(gateOut), 7);
    slots(6);
    chk("R3 no irq before last", int'(irqOut), 0);
    curReq = "R3";
    slots(1);
    chk("R3 irq at last slot", int'(statusOut[0]), 1);
    chk("R3 irq line", int'(irqOut), 1);
    curReq = "R4";
    repeat (5) @(negedge clk);
    chk("R4 sticky", int'(statusOut[0]), 1);
    wr(2'd2, 8'h01);
    chk("R4 cleared", int'(statusOut), 0);
    curReq = "R1";
    slots(19);

    curReq = "R5";
    slots(3);
    wr(2'd1, 8'h0F);
    slots(14);

    curReq = "R2";
    wr(2'd0, 8'h10);
    slots(10);
    chk("R2 acoustic off", int'(gateOut[0]), 0);
    chk("R2 vibrator off", int'(gateOut[2]), 0);
    wr(2'd1, 8'hA5);
    slots(12);

    curReq = "R7";
    wr(2'd0, 8'h79);
    slots(255);
    curReq = "R8";
    slots(1);
    chk("R8 done flag", int'(statusOut[4]), 1);
    wr(2'd2, 8'h11);
    curReq = "R9";
    slots(16);

    curReq = "R7";
    wr(2'd0, 8'hF9);
    slots(256);
    wr(2'd2, 8'h11);
    curReq = "R9";
    slots(5);

    curReq = "R6";
    wr(2'd1, 8'h00);
    slots(1);
    repeat (2) @(negedge clk);
    chk("R6 zero stops", int'(gateOut), 0);
    slots(3);

    curReq = "R11";
    alarmIn = 1'b1;
    @(negedge clk);
    chk("R11 idle extra clock", int'(gateOut), 0);
    @(negedge clk);
    chk("R11 idle alarm on", int'(gateOut), 7);
    alarmIn = 1'b0;
    repeat (3) @(negedge clk);

    curReq = "R10";
    wr(2'd1, 8'h80);
    slots(2);
    alarmIn = 1'b1;
    @(negedge clk);
    chk("R10 alarm over pattern", int'(gateOut), 7);
    alarmIn = 1'b0;
    curReq = "R12";
    slots(10);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule